// File: doc/BRIEF.md
# Programmable 16-bit Down-Count Timer

This block is a general-purpose 16-bit countdown timer with a byte-wide register port. Software places a 16-bit reload value in two byte registers, one for the low half and one for the high half. It then writes a control byte that arms the counter, picks the count source and picks the expiry behaviour. The count source is either the block clock itself, which gives one decrement per cycle, or an external timer clock input. The external input is synchronised and turned into a single-cycle enable on each of its rising edges.

When the count expires, a sticky timeout flag is set. In periodic mode the counter reloads and keeps running. In one-shot mode it parks at zero until software arms it again. The interrupt output is the flag gated by an enable bit. A read of the control register clears the flag, so a service routine acknowledges the event by reading the register it already needs. Reads are combinational on `rdata` in the cycle `rd_en` is high, and every side effect takes place at the next rising edge.

Top module: `dcount_timer`

## Requirements
- R1: After reset, every readable register (control at address 0, reload low at 1, reload high at 2, count low at 3, count high at 4, status at 5) reads 0 and `irq` is 0.
- R2: Addresses 1 and 2 read back the byte last written to them. The control register at address 0 holds bit 0 = interrupt enable, bit 1 = run, bit 2 = one-shot (0 = periodic), bit 3 = external count source (0 = block clock). Its bits 7:4 always read 0.
- R3: A control write with bit 1 set, made while the run bit is 0 (or while the counter is parked after a one-shot expiry), loads the count with {reload high, reload low} at that edge. After that, each count enable lowers the count by one.
- R4: In periodic mode, a count enable that finds the count at 1 or 0 is an expiry. It sets the timeout flag and reloads the count from the reload registers at the same edge.
- R5: In one-shot mode, an expiry sets the flag, forces the count to 0 and stops further counting until a new arming write as in R3.
- R6: While the run bit is 0, the count holds its value. Clearing the run bit does not change the count.
- R7: With bit 3 set, the count advances only on rising edges of `ext_tick_in`, once per edge. A rising edge seen at clock edge k produces its decrement at clock edge k+2. A level held high or low gives no further decrements.
- R8: The timeout flag (status address 5, bit 0) is set by an expiry whatever the interrupt enable is. `irq` equals that flag ANDed with control bit 0.
- R9: A read of address 0 clears the flag at the next edge, unless an expiry happens at that same edge, in which case the flag stays set. Reads of other addresses leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect: clears flag on address 0) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| ext_tick_in | input | 1 | Asynchronous external count clock |
| irq | output | 1 | Timeout interrupt, flag AND enable |

## Verification
The bench targets the edge where an expiry and a control read coincide. A design that lets the clear win there loses an interrupt. It also checks the reload value of zero, which must expire on every enable instead of wrapping to 0xFFFF. Re-arming a parked one-shot with the run bit already set must reload the counter, while rewriting the control byte during a periodic run must not. A design that reloads on every write would restart the period, and one that never re-arms would stay stuck at zero. On the external source, a design that counts levels instead of edges, or that uses a different synchroniser depth, gives a count that drifts from the bench model within a few edges.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

  // Packed MSB first: bit3 clk_ext, bit2 one_shot, bit1 run, bit0 irq_en
  typedef struct packed {
    logic clk_ext;
    logic one_shot;
    logic run;
    logic irq_en;
  } ctrl_t;

  // An enable that finds the count at 1 or 0 ends the period.
  function automatic logic period_ends(input logic [CNT_W-1:0] cnt);
    return (cnt <= CNT_W'(1));
  endfunction

  // Count value after an enable, given mode and reload.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] rld,
                                                  input logic one_shot);
    if (period_ends(cnt)) return one_shot ? '0 : rld;
    return cnt - CNT_W'(1);
  endfunction
endpackage

// File: rtl/dct_clk_sel.sv
module dct_clk_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic ext_in,
  output logic tick,
  output logic ext_edge
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ext_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];

  assign ext_edge = sync_q[SYNC_STAGES-1] & ~last_q;
  assign tick     = use_ext ? ext_edge : 1'b1;

  assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);
endmodule

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              halted,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              arm_load,
  output logic              flag_clr,
  output logic [BYTE_W-1:0] rdata
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] rld_lo_q, rld_hi_q;
  logic              wr_ctrl;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign arm_load = wr_ctrl && wdata[1] && (!ctrl_q.run || halted);
  assign flag_clr = rd_en && (addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rld_lo_q <= '0;
      rld_hi_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:   ctrl_q   <= ctrl_t'(wdata[3:0]);
        A_RLD_LO: rld_lo_q <= wdata;
        A_RLD_HI: rld_hi_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:   rdata = {{(BYTE_W-4){1'b0}}, ctrl_q};
      A_RLD_LO: rdata = rld_lo_q;
      A_RLD_HI: rdata = rld_hi_q;
      A_CNT_LO: rdata = cnt[BYTE_W-1:0];
      A_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
      A_STAT:   rdata = {{(BYTE_W-1){1'b0}}, flag};
      default:  rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign reload = {rld_hi_q, rld_lo_q};

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/dct_core.sv
module dct_core
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] reload,
  input  logic             arm_load,
  input  logic             tick,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             halted,
  output logic             flag,
  output logic             expiry
);
  logic [CNT_W-1:0] cnt_q;
  logic             halt_q, flag_q, counting;

  assign counting = ctrl.run && !halt_q && !arm_load && tick;
  assign expiry   = counting && period_ends(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (arm_load) begin
      cnt_q  <= reload;
      halt_q <= 1'b0;
    end else if (counting) begin
      cnt_q <= next_count(cnt_q, reload, ctrl.one_shot);
      if (expiry && ctrl.one_shot) halt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expiry)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign cnt    = cnt_q;
  assign halted = halt_q;
  assign flag   = flag_q;

  assert_arm_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_load |=> cnt_q == $past(reload));
  assert_periodic_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry && !ctrl.one_shot) |=> cnt_q == $past(reload));
  assert_oneshot_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry && ctrl.one_shot) |=> (cnt_q == '0 && halt_q));
  assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !arm_load) |=> $stable(cnt_q));
  assert_expiry_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |=> flag_q);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              ext_tick_in,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             arm_load, flag_clr, halted, flag, expiry, tick, ext_edge;

  dct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .halted(halted), .cnt(cnt), .flag(flag), .ctrl(ctrl),
    .reload(reload), .arm_load(arm_load), .flag_clr(flag_clr), .rdata(rdata)
  );

  dct_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
    .clk(clk), .rst_n(rst_n), .use_ext(ctrl.clk_ext), .ext_in(ext_tick_in),
    .tick(tick), .ext_edge(ext_edge)
  );

  dct_core u_core (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .reload(reload), .arm_load(arm_load),
    .tick(tick), .flag_clr(flag_clr), .cnt(cnt), .halted(halted), .flag(flag),
    .expiry(expiry)
  );

  assign irq = flag & ctrl.irq_en;

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (flag && ctrl.irq_en));
  assert_ext_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.clk_ext && !ext_edge && !arm_load) |=> $stable(cnt));
endmodule

// File: tb/tb_dcount_timer.sv
module tb_dcount_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_tick_in = 1'b0;
  logic       irq;

  int n_chk = 0, n_bad = 0;

  // reference state
  logic [3:0]  m_ctrl;
  logic [7:0]  m_lo, m_hi;
  logic [15:0] m_cnt;
  logic        m_halt, m_flag, m_s1, m_s2, m_s3;

  dcount_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ext_tick_in(ext_tick_in), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {4'h0, m_ctrl};
      3'd1: return m_lo;
      3'd2: return m_hi;
      3'd3: return m_cnt[7:0];
      3'd4: return m_cnt[15:8];
      3'd5: return {7'h0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_ctrl = 0; m_lo = 0; m_hi = 0; m_cnt = 0;
    m_halt = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
  endtask

  // Restatement of R3..R9 over one clock edge
  task automatic m_edge(input logic w, input logic r, input logic [2:0] a,
                        input logic [7:0] d, input logic ext);
    logic en, arm, expd;
    logic [15:0] rl;
    rl   = {m_hi, m_lo};
    en   = m_ctrl[3] ? (m_s2 && !m_s3) : 1'b1;
    arm  = w && a == 3'd0 && d[1] && (!m_ctrl[1] || m_halt);
    expd = 1'b0;
    if (arm) begin
      m_cnt = rl; m_halt = 0;
    end else if (m_ctrl[1] && !m_halt && en) begin
      if (m_cnt == 0 || m_cnt == 1) begin
        expd = 1'b1;
        if (m_ctrl[2]) begin m_cnt = 0; m_halt = 1; end
        else m_cnt = rl;
      end else m_cnt = m_cnt - 16'd1;
    end
    if (expd) m_flag = 1;
    else if (r && a == 3'd0) m_flag = 0;
    if (w) case (a)
      3'd0: m_ctrl = d[3:0];
      3'd1: m_lo = d;
      3'd2: m_hi = d;
      default: ;
    endcase
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext;
  endtask

  task automatic step(input logic w, input logic r, input logic [2:0] a,
                      input logic [7:0] d, input string tag);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) check({tag, " rdata"}, 16'(rdata), 16'(m_read(a)));
    @(posedge clk);
    m_edge(w, r, a, d, ext_tick_in);
    @(negedge clk);
    check({tag, " irq"}, 16'(irq), 16'(m_flag & m_ctrl[0]));
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, a, d, tag);
  endtask

  // read, compare with literal expectation (plus model check inside step)
  task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
    wr_en = 0; rd_en = 1; addr = a; #1;
    check({tag, " literal"}, 16'(rdata), 16'(e));
    #0;
    step(1'b0, 1'b1, a, 8'h00, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'h00, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    for (int a = 0; a < 6; a++) rd_exp(3'(a), 8'h00, "R1 reset reg");
    check("R1 irq after reset", 16'(irq), 16'd0);

    // R2: reload read-back, reserved control bits
    wr(3'd1, 8'hA5, "R2"); wr(3'd2, 8'h3C, "R2");
    rd_exp(3'd1, 8'hA5, "R2 reload lo");
    rd_exp(3'd2, 8'h3C, "R2 reload hi");
    wr(3'd0, 8'hF0, "R2");
    rd_exp(3'd0, 8'h00, "R2 reserved bits");

    // R3/R4: periodic, reload 3
    wr(3'd1, 8'h03, "R3"); wr(3'd2, 8'h00, "R3");
    wr(3'd0, 8'h03, "R3 arm");
    rd_exp(3'd3, 8'h03, "R3 loaded");
    rd_exp(3'd3, 8'h02, "R3 decrement");
    rd_exp(3'd3, 8'h01, "R3 decrement");
    check("R4 irq on expiry", 16'(irq), 16'd1);
    rd_exp(3'd3, 8'h03, "R4 reloaded");

    // R6: pause keeps value; R9: status read does not clear, ctrl read does
    wr(3'd0, 8'h01, "R6 pause");
    rd_exp(3'd3, 8'h01, "R6 paused value");
    rd_exp(3'd3, 8'h01, "R6 still paused");
    rd_exp(3'd5, 8'h01, "R9 status no clear");
    check("R9 irq kept after status read", 16'(irq), 16'd1);
    rd_exp(3'd0, 8'h01, "R9 ctrl read");
    check("R9 irq cleared by ctrl read", 16'(irq), 16'd0);

    // R5: one-shot, reload 2
    wr(3'd1, 8'h02, "R5");
    wr(3'd0, 8'h07, "R5 arm");
    idle(2);
    check("R5 irq on one-shot expiry", 16'(irq), 16'd1);
    idle(3);
    rd_exp(3'd3, 8'h00, "R5 parked at zero");
    wr(3'd0, 8'h07, "R5 rearm while run set");
    rd_exp(3'd3, 8'h02, "R5 rearmed");

    // R9: expiry at same edge as ctrl read keeps the flag
    wr(3'd0, 8'h00, "R9 stop");
    rd_exp(3'd0, 8'h00, "R9 clear");
    wr(3'd1, 8'h01, "R9");
    wr(3'd0, 8'h03, "R9 arm");           // count 1: expires at next edge
    rd_exp(3'd0, 8'h03, "R9 read on expiry edge");
    check("R9 expiry wins over clear", 16'(irq), 16'd1);

    // R8: flag sets with enable off, reload 0 expires each enable
    wr(3'd0, 8'h00, "R8 stop");
    rd_exp(3'd0, 8'h00, "R8 clear");
    wr(3'd1, 8'h00, "R8");
    wr(3'd0, 8'h02, "R8 arm masked");
    idle(2);
    check("R8 irq masked", 16'(irq), 16'd0);
    rd_exp(3'd5, 8'h01, "R8 flag set while masked");
    rd_exp(3'd3, 8'h00, "R8 reload zero no wrap");
    wr(3'd0, 8'h03, "R8 unmask");
    check("R8 irq follows enable", 16'(irq), 16'd1);

    // R7: external source, reload 10
    wr(3'd0, 8'h00, "R7 stop");
    wr(3'd1, 8'h0A, "R7");
    wr(3'd0, 8'h0A, "R7 arm ext");
    idle(5);
    rd_exp(3'd3, 8'h0A, "R7 no edges no count");
    ext_tick_in = 1'b1;
    idle(3);
    rd_exp(3'd3, 8'h09, "R7 one edge one count");
    idle(6);
    rd_exp(3'd3, 8'h09, "R7 high level no count");
    ext_tick_in = 1'b0;
    idle(4);
    rd_exp(3'd3, 8'h09, "R7 falling edge no count");

    // Random phase (R2..R9 against the reference)
    for (int i = 0; i < 4000; i++) begin
      int unsigned k;
      logic [2:0] a;
      logic [7:0] d;
      k = $urandom_range(0, 99);
      if ($urandom_range(0, 3) == 0) ext_tick_in = ~ext_tick_in;
      a = 3'($urandom_range(0, 6));
      d = 8'($urandom);
      if (k < 15) begin
        if (a == 3'd2) d = 8'h00;
        if (a == 3'd1) d = d & 8'h07;
        step(1'b1, 1'b0, a, d, "R3 rnd write");
      end else if (k < 60) step(1'b0, 1'b1, a, 8'h00, "R4 rnd read");
      else step(1'b0, 1'b0, 3'd0, 8'h00, "R5 rnd idle");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule